// File: doc/BRIEF.md
# Secondary Interrupt Concentrator with Direct Forwarding

This block collects a 32-bit vector of level-sensitive interrupt requests and condenses them into one request line for an upstream interrupt controller. Software sets a per-source enable mask. The combined line is high whenever at least one enabled source is active. Source 0 does not come from a pin. It is a flip-flop that software raises and lowers, which gives a software-generated interrupt.

A second enable register can forward each of sources 21 through 30 on its own dedicated output line. Each of these lines feeds a separate input of the upstream controller. This path does not use the combined line or the enable mask. Software reaches every register through a plain word-addressed bus with combinational read data. Both the combined line and the forwarded lines are registered.

Top module: `sec_irq_ctrl`

## Requirements
- R1: Registers sit on 32-bit words, selected by byte address bits [ADDR_W-1:2]. Reads return the following: word 0 gives raw AND enable mask, word 1 gives the raw level vector, word 2 gives the enable mask, word 4 gives {31'b0, raw bit 0}, and word 8 gives the forwarding enable.
- R2: A write to word 2 ORs the write data into the enable mask.
- R3: A write to word 3 clears every enable mask bit where the write data holds a one.
- R4: `irq_combined` is high exactly when (raw AND enable mask) is nonzero. It is registered, so it reflects the inputs and the register writes presented before the sampling clock edge.
- R5: A write to word 8 ORs (write data AND 0x7FE00000) into the forwarding enable. Bits outside 21..30 are never set.
- R6: A write to word 9 clears every forwarding enable bit where the write data holds a one.
- R7: `irq_direct[i]` (i = 0..9) carries source 21+i. It equals the raw level of that source when its forwarding enable bit is set, and 0 otherwise. It is registered with the same timing as R4.
- R8: Raw bit 0 is a software flip-flop. A nonzero write to word 4 sets it, a nonzero write to word 5 clears it, and a zero write to either word leaves it unchanged. `irq_src[0]` has no effect.
- R9: Reads of unmapped words (3, 5, 6, 7, 9 and above) return 0. Writes to words 0, 1, 6, 7 and 10 and above change no state.
- R10: After reset the enable mask, the forwarding enable and the software flip-flop are 0, and all outputs are low.
- R11: Raw bits 1..31 follow `irq_src` level-sensitively. Each bit reads as 1 while its input is high and as 0 once the input drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W (12) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_src | input | 32 | Level-sensitive interrupt sources (bit 0 unused) |
| irq_combined | output | 1 | Combined masked request to the upstream controller |
| irq_direct | output | 10 | Forwarded requests for sources 21..30 |

## Verification
Random source vectors are mixed with random writes to all sixteen low word offsets. A small share of those writes carry zero data. This exposes mixed-up set and clear decoding, and it exposes a soft flip-flop that reacts to zero writes. Directed cases cover several things. A forwarding write of all ones checks that bits outside 21..30 are masked. Toggling `irq_src[0]` alone checks that the pin is ignored. Writes to read-only and unmapped words are each followed by register reads, so a stray state change shows up. Sources that are active but disabled separate the masked path from the raw path. Forwarded sources with the enable mask cleared show that the forwarding path is independent of the combined line.

// File: rtl/sec_irq_pkg.sv
package sec_irq_pkg;

  // Word offsets; software depends on these positions.
  localparam int unsigned WORD_STAT    = 0;
  localparam int unsigned WORD_RAW     = 1;
  localparam int unsigned WORD_EN_SET  = 2;
  localparam int unsigned WORD_EN_CLR  = 3;
  localparam int unsigned WORD_SW_SET  = 4;
  localparam int unsigned WORD_SW_CLR  = 5;
  localparam int unsigned WORD_FWD_SET = 8;
  localparam int unsigned WORD_FWD_CLR = 9;

  // Contiguous bit mask from lo to hi inclusive.
  function automatic logic [31:0] span_mask(int unsigned lo, int unsigned hi);
    logic [31:0] m;
    m = '0;
    for (int unsigned b = 0; b < 32; b++) begin
      if (b >= lo && b <= hi) m[b] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/sec_irq_rst_sync.sv
module sec_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sec_irq_regs.sv
module sec_irq_regs
  import sec_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned FWD_LO = 21,
  parameter int unsigned FWD_HI = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] en_q,
  output logic [DATA_W-1:0] fwd_q,
  output logic              sw_q,
  output logic [DATA_W-1:0] en_nxt,
  output logic [DATA_W-1:0] fwd_nxt,
  output logic              sw_nxt
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam logic [DATA_W-1:0] FWD_MASK = DATA_W'(span_mask(FWD_LO, FWD_HI));
  localparam logic [WORD_W-1:0] A_STAT    = WORD_W'(WORD_STAT);
  localparam logic [WORD_W-1:0] A_RAW     = WORD_W'(WORD_RAW);
  localparam logic [WORD_W-1:0] A_EN_SET  = WORD_W'(WORD_EN_SET);
  localparam logic [WORD_W-1:0] A_EN_CLR  = WORD_W'(WORD_EN_CLR);
  localparam logic [WORD_W-1:0] A_SW_SET  = WORD_W'(WORD_SW_SET);
  localparam logic [WORD_W-1:0] A_SW_CLR  = WORD_W'(WORD_SW_CLR);
  localparam logic [WORD_W-1:0] A_FWD_SET = WORD_W'(WORD_FWD_SET);
  localparam logic [WORD_W-1:0] A_FWD_CLR = WORD_W'(WORD_FWD_CLR);

  logic [WORD_W-1:0] word;
  logic              en_ce;
  logic              fwd_ce;
  logic              sw_ce;
  logic [1:0]        unused_byte_sel;

  assign word            = addr[ADDR_W-1:2];
  assign unused_byte_sel = addr[1:0];

  // Next-state for the three state registers.
  always_comb begin
    en_nxt  = en_q;
    fwd_nxt = fwd_q;
    sw_nxt  = sw_q;
    en_ce   = 1'b0;
    fwd_ce  = 1'b0;
    sw_ce   = 1'b0;
    if (we) begin
      unique case (word)
        A_EN_SET:  begin en_nxt  = en_q | wdata;               en_ce  = 1'b1; end
        A_EN_CLR:  begin en_nxt  = en_q & ~wdata;              en_ce  = 1'b1; end
        A_FWD_SET: begin fwd_nxt = fwd_q | (wdata & FWD_MASK); fwd_ce = 1'b1; end
        A_FWD_CLR: begin fwd_nxt = fwd_q & ~wdata;             fwd_ce = 1'b1; end
        A_SW_SET:  if (|wdata) begin sw_nxt = 1'b1; sw_ce = 1'b1; end
        A_SW_CLR:  if (|wdata) begin sw_nxt = 1'b0; sw_ce = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else if (en_ce) en_q <= en_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fwd_q <= '0;
    else if (fwd_ce) fwd_q <= fwd_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= 1'b0;
    else if (sw_ce) sw_q <= sw_nxt;
  end

  // Combinational read mux.
  always_comb begin
    unique case (word)
      A_STAT:    rdata = raw & en_q;
      A_RAW:     rdata = raw;
      A_EN_SET:  rdata = en_q;
      A_SW_SET:  rdata = {{(DATA_W-1){1'b0}}, raw[0]};
      A_FWD_SET: rdata = fwd_q;
      default:   rdata = '0;
    endcase
  end

  assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && word == A_EN_SET) |=> ((en_q & $past(wdata)) == $past(wdata)));

  assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && word == A_EN_CLR) |=> ((en_q & $past(wdata)) == '0));

  assert_fwd_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_q & ~FWD_MASK) == '0);

  assert_fwd_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && word == A_FWD_CLR) |=> ((fwd_q & $past(wdata)) == '0));

  assert_sw_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && word == A_SW_SET && wdata != '0) |=> sw_q);

  assert_sw_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (word == A_SW_SET || word == A_SW_CLR) && wdata == '0) |=> $stable(sw_q));

  assert_ro_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (word == A_STAT || word == A_RAW)) |=> ($stable(en_q) && $stable(fwd_q) && $stable(sw_q)));
endmodule

// File: rtl/sec_irq_route.sv
module sec_irq_route #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned FWD_LO = 21,
  parameter int unsigned FWD_HI = 30
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [DATA_W-1:0]          irq_src,
  input  logic                       sw_q,
  input  logic                       sw_nxt,
  input  logic [DATA_W-1:0]          en_nxt,
  input  logic [DATA_W-1:0]          fwd_nxt,
  input  logic [DATA_W-1:0]          fwd_q,
  output logic [DATA_W-1:0]          raw,
  output logic                       irq_comb,
  output logic [FWD_HI-FWD_LO:0]     irq_fwd
);
  localparam int unsigned FWD_N = FWD_HI - FWD_LO + 1;

  logic [DATA_W-1:0] raw_nxt;
  logic              comb_d;
  logic [FWD_N-1:0]  fwd_d;
  logic              unused_pin0;

  assign unused_pin0 = irq_src[0];
  assign raw         = {irq_src[DATA_W-1:1], sw_q};
  assign raw_nxt     = {irq_src[DATA_W-1:1], sw_nxt};

  always_comb begin
    comb_d = |(raw_nxt & en_nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_comb <= 1'b0;
    else        irq_comb <= comb_d;
  end

  for (genvar i = 0; i < FWD_N; i++) begin : g_fwd
    always_comb begin
      fwd_d[i] = raw_nxt[FWD_LO+i] & fwd_nxt[FWD_LO+i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_fwd[i] <= 1'b0;
      else        irq_fwd[i] <= fwd_d[i];
    end

    assert_fwd_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !fwd_q[FWD_LO+i] |-> !irq_fwd[i]);

    assert_fwd_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_fwd[i] |-> $past(irq_src[FWD_LO+i]));
  end

  assert_comb_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_comb |-> ($past(|irq_src[DATA_W-1:1]) || sw_q));
endmodule

// File: rtl/sec_irq_ctrl.sv
module sec_irq_ctrl #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned FWD_LO = 21,
  parameter int unsigned FWD_HI = 30
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_we,
  input  logic [DATA_W-1:0]      bus_wdata,
  output logic [DATA_W-1:0]      bus_rdata,
  input  logic [DATA_W-1:0]      irq_src,
  output logic                   irq_combined,
  output logic [FWD_HI-FWD_LO:0] irq_direct
);
  logic              rst_sync_n;
  logic [DATA_W-1:0] raw;
  logic [DATA_W-1:0] en_q;
  logic [DATA_W-1:0] fwd_q;
  logic              sw_q;
  logic [DATA_W-1:0] en_nxt;
  logic [DATA_W-1:0] fwd_nxt;
  logic              sw_nxt;
  logic [DATA_W-1:0] unused_en_q;

  assign unused_en_q = en_q;

  sec_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sec_irq_regs #(
    .DATA_W (DATA_W), .ADDR_W (ADDR_W), .FWD_LO (FWD_LO), .FWD_HI (FWD_HI)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .addr    (bus_addr),
    .we      (bus_we),
    .wdata   (bus_wdata),
    .raw     (raw),
    .rdata   (bus_rdata),
    .en_q    (en_q),
    .fwd_q   (fwd_q),
    .sw_q    (sw_q),
    .en_nxt  (en_nxt),
    .fwd_nxt (fwd_nxt),
    .sw_nxt  (sw_nxt)
  );

  sec_irq_route #(
    .DATA_W (DATA_W), .FWD_LO (FWD_LO), .FWD_HI (FWD_HI)
  ) u_route (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .irq_src  (irq_src),
    .sw_q     (sw_q),
    .sw_nxt   (sw_nxt),
    .en_nxt   (en_nxt),
    .fwd_nxt  (fwd_nxt),
    .fwd_q    (fwd_q),
    .raw      (raw),
    .irq_comb (irq_combined),
    .irq_fwd  (irq_direct)
  );

  assert_reset_R10: assert property (@(posedge clk) !rst_sync_n |=> (!irq_combined && irq_direct == '0));
endmodule

// File: tb/sec_irq_ctrl_test.sv
`timescale 1ns/1ps
module sec_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] irq_src;
  logic        irq_combined;
  logic [9:0]  irq_direct;

  int n_run  = 0;
  int n_fail = 0;
  logic [31:0] m_en, m_fwd, m_src;
  logic        m_sw;

  always #2 clk = ~clk;

  sec_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(irq_src),
    .irq_combined(irq_combined), .irq_direct(irq_direct)
  );

  function automatic logic [31:0] m_raw();
    return {m_src[31:1], m_sw};
  endfunction

  function automatic logic [9:0] m_direct();
    logic [31:0] r;
    r = m_raw() & m_fwd;
    return r[30:21];
  endfunction

  function automatic logic [31:0] m_read(int w);
    case (w)
      0: return m_raw() & m_en;
      1: return m_raw();
      2: return m_en;
      4: return {31'b0, m_sw};
      8: return m_fwd;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(int w, string req);
    bus_we   = 1'b0;
    bus_addr = 12'(w * 4);
    #0.5;
    chk(req, bus_rdata, m_read(w));
  endtask

  // Drive one cycle at the falling edge, update the model, check at next falling edge.
  task automatic step(logic we, int w, logic [31:0] d, logic [31:0] src);
    bus_we = we; bus_addr = 12'(w * 4); bus_wdata = d; irq_src = src;
    m_src = src;
    if (we) begin
      case (w)
        2: m_en  = m_en | d;
        3: m_en  = m_en & ~d;
        4: if (d != 0) m_sw = 1'b1;
        5: if (d != 0) m_sw = 1'b0;
        8: m_fwd = m_fwd | (d & 32'h7FE0_0000);
        9: m_fwd = m_fwd & ~d;
        default: ;
      endcase
    end
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
    chk("R4 combined", {31'b0, irq_combined}, {31'b0, |(m_raw() & m_en)});
    chk("R7 direct", {22'b0, irq_direct}, {22'b0, m_direct()});
  endtask

  task automatic rd_all();
    rd(0, "R1 masked"); rd(1, "R11 raw"); rd(2, "R1 enable");
    rd(4, "R1 soft"); rd(8, "R1 forward");
  endtask

  initial begin
    #600000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; irq_src = '0;
    m_en = '0; m_fwd = '0; m_sw = 1'b0; m_src = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 combined", {31'b0, irq_combined}, 32'h0);
    chk("R10 direct", {22'b0, irq_direct}, 32'h0);
    rd(2, "R10 enable"); rd(8, "R10 forward"); rd(4, "R10 soft");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11 raw follows, R4 disabled sources stay quiet
    step(1'b0, 0, 0, 32'h0000_F0F0);
    chk("R4 disabled", {31'b0, irq_combined}, 32'h0);
    rd(1, "R11 raw high");
    step(1'b0, 0, 0, 32'h0000_0000);
    rd(1, "R11 raw low");
    // R2 / R3
    step(1'b1, 2, 32'h0000_00F0, 32'h0000_0010);
    rd(2, "R2 set"); rd(0, "R1 status");
    chk("R4 enabled", {31'b0, irq_combined}, 32'h1);
    step(1'b1, 2, 32'h8000_0000, 32'h0000_0010);
    rd(2, "R2 accumulate");
    step(1'b1, 3, 32'h0000_0010, 32'h0000_0010);
    rd(2, "R3 clear");
    chk("R3 combined drops", {31'b0, irq_combined}, 32'h0);
    // R5 / R6 / R7
    step(1'b1, 8, 32'hFFFF_FFFF, 32'h7FE0_0000);
    rd(8, "R5 range only");
    chk("R7 forward all", {22'b0, irq_direct}, 32'h3FF);
    step(1'b1, 9, 32'h0020_0000, 32'h7FE0_0000);
    chk("R6 clear bit21", {22'b0, irq_direct}, 32'h3FE);
    step(1'b0, 0, 0, 32'h4000_0000);
    chk("R7 follows level", {22'b0, irq_direct}, 32'h200);
    // R8 soft interrupt, pin 0 ignored
    step(1'b0, 0, 0, 32'h0000_0001);
    rd(1, "R8 pin0 ignored");
    step(1'b1, 2, 32'h0000_0001, 32'h0000_0001);
    chk("R8 pin0 no irq", {31'b0, irq_combined}, 32'h0);
    step(1'b1, 4, 32'h0, 32'h0);
    rd(4, "R8 zero set");
    step(1'b1, 4, 32'h0000_0100, 32'h0);
    rd(4, "R8 set");
    chk("R8 soft irq", {31'b0, irq_combined}, 32'h1);
    step(1'b1, 5, 32'h0, 32'h0);
    rd(4, "R8 zero clear");
    step(1'b1, 5, 32'h1, 32'h0);
    rd(4, "R8 clear");
    // R9 ignored writes and unmapped reads
    step(1'b1, 0, 32'hFFFF_FFFF, 32'h0);
    step(1'b1, 1, 32'hFFFF_FFFF, 32'h0);
    step(1'b1, 6, 32'hFFFF_FFFF, 32'h0);
    step(1'b1, 12, 32'hFFFF_FFFF, 32'h0);
    rd(2, "R9 enable kept"); rd(8, "R9 forward kept"); rd(4, "R9 soft kept");
    rd(3, "R9 unmapped 3"); rd(5, "R9 unmapped 5"); rd(7, "R9 unmapped 7");
    rd(9, "R9 unmapped 9"); rd(13, "R9 unmapped 13");

    // Random mix
    for (int k = 0; k < 400; k++) begin
      int w;
      logic [31:0] d;
      w = int'($urandom % 16);
      d = ($urandom % 4 == 0) ? 32'h0 : $urandom;
      step(($urandom % 3) != 0, w, d, $urandom);
      rd_all();
      rd(int'($urandom % 16), "R9 random read");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule